// File: doc/BRIEF.md
# AXI Block Transfer Master

This block accepts a simple host command and turns it into AXI4 memory transactions on a 64-bit data bus. Each command gives a direction (read or write), a transfer mode (single or block) and a 32-bit start address. Single mode moves one 8-byte beat. Block mode moves 2048 bytes as a chain of sixteen 16-beat INCR bursts. The address advances by 128 bytes from one burst to the next.

Write beats come from a ready/valid data port and go straight to the AXI write data channel. Read beats leave through a port that is qualified by a valid strobe. A one-cycle done pulse marks the end of each command. Only one burst is in flight at any time. The next address phase starts only after the previous burst has completed: for a write this is the write response, for a read it is the final read beat. A non-OKAY write response sets an error flag that stays set until reset.

Top module: `axbm_engine`

## Requirements
- R1: After reset, cmd_ready is 1, and done, err, awvalid, arvalid, wvalid, bready and rready are all 0.
- R2: The three low address bits of the command are cleared. Every awaddr and araddr issued is a multiple of 8.
- R3: A single-mode command issues exactly one address phase with len 0 and moves one beat. For a write, that beat has wlast = 1.
- R4: A block-mode command issues 16 address phases, each with len 15. The first carries the aligned start address, and each later one is 128 above the one before it. The command moves 256 beats in total.
- R5: Every address phase carries size 3 (8 bytes) and burst type 2'b01 (INCR).
- R6: Write beats carry wd_data unchanged and in arrival order. wlast is 1 exactly on the 16th beat of each block-mode burst, and 0 on every other beat of that burst.
- R7: No address phase is issued while an earlier burst of the same command is incomplete. A write burst is complete at its write-response handshake. A read burst is complete at its last data handshake.
- R8: Read beats appear on rd_valid/rd_data in order with the data returned by memory. rready is 0 while a write command is running, and wvalid is 0 while a read command is running.
- R9: done is high for exactly one cycle. It rises in the cycle after the final write-response handshake or the final read-data handshake. cmd_ready is 0 from the cycle after a command is accepted until done.
- R10: A write response with bresp != 2'b00 sets err. err stays 1 through later error-free commands and is cleared only by reset.
- R11: Once awvalid or arvalid is raised, it stays high with a stable address until the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command accepted |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_block | input | 1 | 1 = 2048-byte block mode, 0 = single beat |
| cmd_addr | input | 32 | Start byte address |
| wd_valid | input | 1 | Write beat offered |
| wd_ready | output | 1 | Write beat taken |
| wd_data | input | 64 | Write beat data |
| rd_valid | output | 1 | Read beat valid |
| rd_data | output | 64 | Read beat data |
| done | output | 1 | Command finished pulse |
| err | output | 1 | Sticky write-response error |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awaddr | output | 32 | Write address |
| awlen | output | 8 | Write burst length minus one |
| awsize | output | 3 | Write beat size code |
| awburst | output | 2 | Write burst type |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wdata | output | 64 | Write data |
| wstrb | output | 8 | Write byte strobes |
| wlast | output | 1 | Last write beat of burst |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| bresp | input | 2 | Write response code |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| araddr | output | 32 | Read address |
| arlen | output | 8 | Read burst length minus one |
| arsize | output | 3 | Read beat size code |
| arburst | output | 2 | Read burst type |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |
| rdata | input | 64 | Read data |
| rresp | input | 2 | Read response code |
| rlast | input | 1 | Last read beat |

## Verification
The data-path strobes (wvalid, wd_ready, rd_valid, wlast) follow the inputs in the same cycle. The bench samples them at the falling edge, so it sees the values that the next rising edge acts on. Address-phase and response-phase changes take effect one edge after the handshake that causes them. done and the err update are due exactly one rising edge after the final handshake. The bench records each handshake at a falling edge and requires done at the following falling edge and at no other. Write-data ordering, wlast placement and address stepping are checked afterwards, against handshake logs collected under slave stalls and without them.

// File: rtl/axbm_pkg.sv
package axbm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_AW,
        ST_WD,
        ST_WB,
        ST_AR,
        ST_RD
    } axbm_state_e;

    typedef struct packed {
        logic is_write;
        logic is_block;
    } axbm_cmd_t;

    localparam logic [1:0] AXI_INCR = 2'b01;
    localparam logic [1:0] AXI_OKAY = 2'b00;

    function automatic logic [2:0] size_code(input int bytes);
        return 3'($clog2(bytes));
    endfunction

endpackage

// File: rtl/axbm_seq.sv
// Burst sequencer: holds the current burst address and counts bursts.
module axbm_seq #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 128,
    parameter int COUNT  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              advance,
    input  logic              block_mode,
    output logic [ADDR_W-1:0] addr,
    output logic              last_burst
);
    localparam int CW = (COUNT > 1) ? $clog2(COUNT) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            addr  <= start_addr;
            cnt_q <= '0;
        end else if (advance) begin
            addr  <= addr + ADDR_W'(STEP);
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last_burst = !block_mode || (cnt_q == CW'(COUNT - 1));
endmodule

// File: rtl/axbm_beat.sv
// Beat counter within one burst.
module axbm_beat #(
    parameter int BEATS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic advance,
    input  logic block_mode,
    output logic last_beat
);
    localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;

    logic [BW-1:0] beat_q;

    always_ff @(posedge clk) begin
        if (rst || clear) beat_q <= '0;
        else if (advance) beat_q <= beat_q + 1'b1;
    end

    assign last_beat = !block_mode || (beat_q == BW'(BEATS - 1));
endmodule

// File: rtl/axbm_engine.sv
module axbm_engine
    import axbm_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 64,
    parameter int BURST_BEATS = 16,
    parameter int BURST_COUNT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic              cmd_block,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              wd_valid,
    output logic              wd_ready,
    input  logic [DATA_W-1:0] wd_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              err,
    output logic              awvalid,
    input  logic              awready,
    output logic [ADDR_W-1:0] awaddr,
    output logic [7:0]        awlen,
    output logic [2:0]        awsize,
    output logic [1:0]        awburst,
    output logic              wvalid,
    input  logic              wready,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W/8-1:0] wstrb,
    output logic              wlast,
    input  logic              bvalid,
    output logic              bready,
    input  logic [1:0]        bresp,
    output logic              arvalid,
    input  logic              arready,
    output logic [ADDR_W-1:0] araddr,
    output logic [7:0]        arlen,
    output logic [2:0]        arsize,
    output logic [1:0]        arburst,
    input  logic              rvalid,
    output logic              rready,
    input  logic [DATA_W-1:0] rdata,
    input  logic [1:0]        rresp,
    input  logic              rlast
);
    localparam int BYTES = DATA_W / 8;
    localparam int OFS   = $clog2(BYTES);
    localparam int STEP  = BURST_BEATS * BYTES;
    localparam logic [7:0] LEN_BLK = 8'(BURST_BEATS - 1);

    axbm_state_e state_q, state_d;
    axbm_cmd_t   cmd_q;
    logic        done_q, err_q;
    logic        load, seq_adv, beat_clr, beat_adv;
    logic        last_burst, last_beat;
    logic [ADDR_W-1:0] cur_addr, start_aligned;
    logic        w_hs, r_hs, b_hs;
    logic        unused_r;

    assign start_aligned = {cmd_addr[ADDR_W-1:OFS], {OFS{1'b0}}};
    assign unused_r      = ^{rresp, rlast};

    assign w_hs = (state_q == ST_WD) && wd_valid && wready;
    assign r_hs = (state_q == ST_RD) && rvalid;
    assign b_hs = (state_q == ST_WB) && bvalid;

    assign load     = (state_q == ST_IDLE) && cmd_valid;
    assign beat_clr = (state_q == ST_AW) || (state_q == ST_AR);
    assign beat_adv = w_hs || r_hs;
    assign seq_adv  = (b_hs && !last_burst) || (r_hs && last_beat && !last_burst);

    axbm_seq #(.ADDR_W(ADDR_W), .STEP(STEP), .COUNT(BURST_COUNT)) seq_i (
        .clk(clk), .rst(rst), .load(load), .start_addr(start_aligned),
        .advance(seq_adv), .block_mode(cmd_q.is_block),
        .addr(cur_addr), .last_burst(last_burst)
    );

    axbm_beat #(.BEATS(BURST_BEATS)) beat_i (
        .clk(clk), .rst(rst), .clear(beat_clr), .advance(beat_adv),
        .block_mode(cmd_q.is_block), .last_beat(last_beat)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_valid) state_d = cmd_write ? ST_AW : ST_AR;
            ST_AW:   if (awready) state_d = ST_WD;
            ST_WD:   if (w_hs && last_beat) state_d = ST_WB;
            ST_WB:   if (bvalid) state_d = last_burst ? ST_IDLE : ST_AW;
            ST_AR:   if (arready) state_d = ST_RD;
            ST_RD:   if (r_hs && last_beat) state_d = last_burst ? ST_IDLE : ST_AR;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cmd_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (b_hs && last_burst) || (r_hs && last_beat && last_burst);
            if (load) cmd_q <= '{is_write: cmd_write, is_block: cmd_block};
            if (b_hs && (bresp != AXI_OKAY)) err_q <= 1'b1;
        end
    end

    assign cmd_ready = (state_q == ST_IDLE);
    assign done      = done_q;
    assign err       = err_q;

    assign awvalid = (state_q == ST_AW);
    assign awaddr  = cur_addr;
    assign awlen   = cmd_q.is_block ? LEN_BLK : 8'd0;
    assign awsize  = size_code(BYTES);
    assign awburst = AXI_INCR;

    assign wvalid   = (state_q == ST_WD) && wd_valid;
    assign wd_ready = (state_q == ST_WD) && wready;
    assign wdata    = wd_data;
    assign wstrb    = '1;
    assign wlast    = (state_q == ST_WD) && last_beat;
    assign bready   = (state_q == ST_WB);

    assign arvalid = (state_q == ST_AR);
    assign araddr  = cur_addr;
    assign arlen   = cmd_q.is_block ? LEN_BLK : 8'd0;
    assign arsize  = size_code(BYTES);
    assign arburst = AXI_INCR;

    assign rready   = (state_q == ST_RD);
    assign rd_valid = r_hs;
    assign rd_data  = rdata;
endmodule

// File: rtl/axbm_chk.sv
module axbm_chk #(
    parameter int ADDR_W = 32,
    parameter int OFS    = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_ready,
    input logic              done,
    input logic              err,
    input logic              awvalid,
    input logic              awready,
    input logic [ADDR_W-1:0] awaddr,
    input logic [7:0]        awlen,
    input logic [2:0]        awsize,
    input logic [1:0]        awburst,
    input logic              wvalid,
    input logic              bready,
    input logic              arvalid,
    input logic              arready,
    input logic [ADDR_W-1:0] araddr,
    input logic [2:0]        arsize,
    input logic [1:0]        arburst,
    input logic              rready
);
    AST_AW_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        awvalid |-> awaddr[OFS-1:0] == '0);                                  // R2
    AST_AR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        arvalid |-> araddr[OFS-1:0] == '0);                                  // R2
    AST_AW_LEN: assert property (@(posedge clk) disable iff (rst)
        awvalid |-> (awlen == 8'd0 || awlen == 8'd15));                      // R4
    AST_AW_FORMAT: assert property (@(posedge clk) disable iff (rst)
        awvalid |-> (awsize == 3'd3 && awburst == 2'b01));                   // R5
    AST_AR_FORMAT: assert property (@(posedge clk) disable iff (rst)
        arvalid |-> (arsize == 3'd3 && arburst == 2'b01));                   // R5
    AST_AW_SOLO: assert property (@(posedge clk) disable iff (rst)
        awvalid |-> !(wvalid || bready || rready || arvalid));               // R7
    AST_AR_SOLO: assert property (@(posedge clk) disable iff (rst)
        arvalid |-> !(wvalid || bready || rready));                          // R7
    AST_RD_EXCL: assert property (@(posedge clk) disable iff (rst)
        rready |-> !(wvalid || bready));                                     // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                     // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> cmd_ready);                                                 // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err |=> err);                                                        // R10
    AST_AW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (awvalid && !awready) |=> (awvalid && $stable(awaddr)));             // R11
    AST_AR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (arvalid && !arready) |=> (arvalid && $stable(araddr)));             // R11
endmodule

bind axbm_engine axbm_chk #(.ADDR_W(ADDR_W), .OFS($clog2(DATA_W / 8))) chk_i (
    .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .done(done), .err(err),
    .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awlen(awlen),
    .awsize(awsize), .awburst(awburst), .wvalid(wvalid), .bready(bready),
    .arvalid(arvalid), .arready(arready), .araddr(araddr), .arsize(arsize),
    .arburst(arburst), .rready(rready)
);

// File: tb/axbm_engine_tb_top.sv
module axbm_engine_tb_top;
    localparam logic [63:0] WBASE = 64'h1111_2222_0000_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        cmd_valid = 0, cmd_write = 0, cmd_block = 0;
    logic [31:0] cmd_addr = '0;
    logic        cmd_ready;
    logic        wd_valid = 0;
    logic [63:0] wd_data = '0;
    logic        wd_ready, rd_valid, done, err;
    logic [63:0] rd_data;
    logic        awvalid, awready = 0;
    logic [31:0] awaddr;
    logic [7:0]  awlen, arlen;
    logic [2:0]  awsize, arsize;
    logic [1:0]  awburst, arburst;
    logic        wvalid, wready = 0, wlast;
    logic [63:0] wdata;
    logic [7:0]  wstrb;
    logic        bvalid = 0, bready;
    logic [1:0]  bresp = 0;
    logic        arvalid, arready = 0;
    logic [31:0] araddr;
    logic        rvalid = 0, rready, rlast = 0;
    logic [63:0] rdata = '0;
    logic [1:0]  rresp = 0;

    axbm_engine dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_write(cmd_write), .cmd_block(cmd_block), .cmd_addr(cmd_addr),
        .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .err(err),
        .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awlen(awlen),
        .awsize(awsize), .awburst(awburst), .wvalid(wvalid), .wready(wready),
        .wdata(wdata), .wstrb(wstrb), .wlast(wlast), .bvalid(bvalid),
        .bready(bready), .bresp(bresp), .arvalid(arvalid), .arready(arready),
        .araddr(araddr), .arlen(arlen), .arsize(arsize), .arburst(arburst),
        .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp),
        .rlast(rlast)
    );

    int n_tests = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mem_word(input logic [31:0] a);
        return {a, ~a};
    endfunction

    // ---------------- handshake logs (sampled at falling edge) ----------------
    logic [31:0] aw_log [0:31];
    logic [7:0]  aw_len_log [0:31];
    logic [31:0] ar_log [0:31];
    logic [7:0]  ar_len_log [0:31];
    logic [63:0] w_log [0:299];
    logic        wl_log [0:299];
    logic [63:0] rd_log [0:299];
    int aw_n, ar_n, w_n, rd_n, b_n, done_n, wd_idx;
    int ord_viol, rr_viol, wv_viol, done_viol;
    int exp_b, exp_r;
    bit aw_open, ar_open, fin_prev, in_write, in_read;
    bit hs_ar, hs_r, hs_b, hs_wlast, hs_wd;
    logic [31:0] ar_addr_s;
    logic [7:0]  ar_len_s;

    always @(negedge clk) begin
        bit fin_now;
        hs_ar    = arvalid && arready;
        hs_r     = rvalid && rready;
        hs_b     = bvalid && bready;
        hs_wd    = wd_valid && wd_ready;
        hs_wlast = hs_wd && wlast;
        fin_now  = 0;
        if (!rst) begin
            if (awvalid && awready) begin
                if (aw_open) ord_viol++;
                aw_open = 1;
                if (aw_n < 32) begin aw_log[aw_n] = awaddr; aw_len_log[aw_n] = awlen; end
                aw_n++;
            end
            if (hs_ar) begin
                if (ar_open) ord_viol++;
                ar_open = 1;
                ar_addr_s = araddr; ar_len_s = arlen;
                if (ar_n < 32) begin ar_log[ar_n] = araddr; ar_len_log[ar_n] = arlen; end
                ar_n++;
            end
            if (hs_wd) begin
                if (!wvalid) ord_viol++;
                if (w_n < 300) begin w_log[w_n] = wdata; wl_log[w_n] = wlast; end
                w_n++;
                wd_idx++;
            end
            if (hs_b) begin
                aw_open = 0;
                b_n++;
                if (b_n == exp_b) fin_now = 1;
            end
            if (rd_valid) begin
                if (rd_n < 300) rd_log[rd_n] = rd_data;
                rd_n++;
                if (rd_n % (int'(ar_len_s) + 1) == 0) ar_open = 0;
                if (rd_n == exp_r) fin_now = 1;
            end
            if (in_write && rready) rr_viol++;
            if (in_read && wvalid) wv_viol++;
            if (done || fin_prev) begin
                if (done != fin_prev) done_viol++;
            end
            if (done) done_n++;
        end
        fin_prev = fin_now;
    end

    // ---------------- memory slave model (drives just after rising edge) ------
    bit stall = 0, bad_resp = 0;
    int cyc = 0, pend_b = 0, r_left = 0;
    logic [31:0] r_addr;

    always @(posedge clk) begin
        bit ga, gb;
        #1;
        cyc++;
        ga = !stall || (cyc % 3 != 1);
        gb = !stall || (cyc % 4 != 2);
        awready = ga;
        arready = gb;
        wready  = ga;
        if (!(wd_valid && !hs_wd)) wd_valid = gb;
        wd_data = WBASE + 64'(wd_idx);
        if (hs_b) begin bvalid = 0; pend_b--; end
        if (hs_wlast) pend_b++;
        if (!bvalid && pend_b > 0 && ga) begin
            bvalid = 1;
            bresp  = bad_resp ? 2'b10 : 2'b00;
        end
        if (hs_ar) begin r_left = int'(ar_len_s) + 1; r_addr = ar_addr_s; end
        if (hs_r) begin r_left--; r_addr += 32'd8; rvalid = 0; end
        if (!rvalid && r_left > 0 && gb) begin
            rvalid = 1;
            rdata  = mem_word(r_addr);
            rlast  = (r_left == 1);
        end
    end

    // ---------------- scenario helpers ----------------
    task automatic clear_logs(input bit blk);
        aw_n = 0; ar_n = 0; w_n = 0; rd_n = 0; b_n = 0; done_n = 0; wd_idx = 0;
        ord_viol = 0; rr_viol = 0; wv_viol = 0; done_viol = 0;
        aw_open = 0; ar_open = 0;
        exp_b = blk ? 16 : 1;
        exp_r = blk ? 256 : 1;
    endtask

    task automatic run_cmd(input bit wr, input bit blk, input logic [31:0] a);
        int t;
        @(posedge clk); #2;
        clear_logs(blk);
        in_write = wr; in_read = !wr;
        cmd_write = wr; cmd_block = blk; cmd_addr = a; cmd_valid = 1;
        @(negedge clk);
        chk(cmd_ready == 1, "R9", "cmd_ready idle", cmd_ready, 1);
        @(posedge clk); #2;
        cmd_valid = 0;
        @(negedge clk);
        chk(cmd_ready == 0, "R9", "cmd_ready busy", cmd_ready, 0);
        t = 0;
        while (done_n == 0 && t < 20000) begin @(negedge clk); t++; end
        chk(done_n == 1, "R9", "done seen", done_n, 1);
        repeat (3) @(negedge clk);
        chk(done_n == 1 && done_viol == 0, "R9", "done single-cycle timing", done_viol, 0);
        chk(ord_viol == 0, "R7", "overlapping bursts", ord_viol, 0);
        in_write = 0; in_read = 0;
    endtask

    task automatic check_addrs(input bit wr, input bit blk, input logic [31:0] a);
        int n, bad;
        logic [31:0] base;
        base = {a[31:3], 3'b000};
        n = wr ? aw_n : ar_n;
        bad = 0;
        chk(n == (blk ? 16 : 1), blk ? "R4" : "R3", "address phase count", n, blk ? 16 : 1);
        for (int k = 0; k < n && k < 32; k++) begin
            logic [31:0] ad;
            logic [7:0]  ln;
            ad = wr ? aw_log[k] : ar_log[k];
            ln = wr ? aw_len_log[k] : ar_len_log[k];
            if (ad != base + 32'(k * 128) || ln != (blk ? 8'd15 : 8'd0)) begin
                if (bad == 0)
                    $display("FAIL R4 burst %0d addr actual=%0h expected=%0h len=%0d",
                             k, ad, base + 32'(k * 128), ln);
                bad++;
            end
        end
        chk(bad == 0, "R2", "aligned stepped addresses", bad, 0);
    endtask

    task automatic t_reset;
        rst = 1;
        repeat (3) @(posedge clk);
        #2 rst = 0;
        @(negedge clk);
        chk(cmd_ready == 1, "R1", "cmd_ready", cmd_ready, 1);
        chk({done, err, awvalid, arvalid, wvalid, bready, rready} == 7'b0, "R1",
            "outputs idle", {done, err, awvalid, arvalid, wvalid, bready, rready}, 0);
    endtask

    task automatic t_write(input bit blk, input logic [31:0] a, input bit stl);
        int bad;
        stall = stl;
        run_cmd(1, blk, a);
        check_addrs(1, blk, a);
        chk(awsize == 3 && awburst == 2'b01, "R5", "aw size/burst", {awsize, awburst}, 5'b01101);
        chk(w_n == (blk ? 256 : 1), "R6", "write beat count", w_n, blk ? 256 : 1);
        bad = 0;
        for (int k = 0; k < w_n && k < 300; k++) begin
            bit el;
            el = blk ? ((k % 16) == 15) : 1'b1;
            if (w_log[k] != WBASE + 64'(k) || wl_log[k] != el) begin
                if (bad == 0)
                    $display("FAIL R6 beat %0d data=%0h/%0h last=%0d/%0d",
                             k, w_log[k], WBASE + 64'(k), wl_log[k], el);
                bad++;
            end
        end
        chk(bad == 0, blk ? "R6" : "R3", "write data and wlast", bad, 0);
        chk(rr_viol == 0, "R8", "rready during write", rr_viol, 0);
        chk(ar_n == 0, "R8", "no read address in write", ar_n, 0);
    endtask

    task automatic t_read(input bit blk, input logic [31:0] a, input bit stl);
        int bad;
        logic [31:0] base;
        stall = stl;
        base = {a[31:3], 3'b000};
        run_cmd(0, blk, a);
        check_addrs(0, blk, a);
        chk(arsize == 3 && arburst == 2'b01, "R5", "ar size/burst", {arsize, arburst}, 5'b01101);
        chk(rd_n == (blk ? 256 : 1), blk ? "R4" : "R3", "read beat count", rd_n, blk ? 256 : 1);
        bad = 0;
        for (int k = 0; k < rd_n && k < 300; k++) begin
            if (rd_log[k] != mem_word(base + 32'(k * 8))) begin
                if (bad == 0)
                    $display("FAIL R8 beat %0d actual=%0h expected=%0h",
                             k, rd_log[k], mem_word(base + 32'(k * 8)));
                bad++;
            end
        end
        chk(bad == 0, "R8", "read data order", bad, 0);
        chk(wv_viol == 0, "R8", "wvalid during read", wv_viol, 0);
    endtask

    task automatic t_error;
        bad_resp = 1;
        t_write(0, 32'h0000_0100, 0);
        bad_resp = 0;
        chk(err == 1, "R10", "err after bad response", err, 1);
        t_write(0, 32'h0000_0108, 1);
        chk(err == 1, "R10", "err sticky after clean write", err, 1);
        t_reset();
        chk(err == 0, "R10", "err cleared by reset", err, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_write(0, 32'h0000_1235, 0);
        chk(err == 0, "R10", "err clear on OKAY", err, 0);
        t_read(0, 32'h0040_0007, 1);
        t_write(1, 32'h0000_2000, 1);
        t_read(1, 32'h03FF_F7F8, 0);
        t_read(1, 32'h0000_2003, 1);
        t_write(0, 32'h03FF_FFF8, 1);
        t_error();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule